// File: doc/BRIEF.md
# Cell and Auxiliary Threshold Alert Checker

This block watches a stream of 32-bit conversion result frames coming back from a battery-monitor chain. Each frame holds a 4-bit channel code and a 12-bit conversion value. The block compares every accepted frame against a pair of 8-bit limits. Cell-voltage channels use one pair and auxiliary (temperature) channels use a separate pair. When a limit is crossed, the block emits a one-cycle event that carries the direction, the channel class and the channel code.

The four limits live in a small register file. A host writes them through a single-cycle write port. The written data is a signed word, and it is saturated into the 8-bit range before it is stored. Frames flagged by an upstream integrity check are dropped before the comparison stage.

Top module: `thr_alert_top`

## Requirements
- R1: A frame whose channel code (frame bits 26..23) is 0 to 5 is compared against the cell limits, and its event reports `evt_aux`=0.
- R2: A frame whose channel code is 6 or more, including codes 12 to 15, is compared against the auxiliary limits, and its event reports `evt_aux`=1.
- R3: If the 12-bit value (frame bits 22..11) is greater than or equal to the zero-extended high limit of its class, the event has `evt_rising`=1. This holds even when the value is also at or below the low limit.
- R4: If the value is below the high limit and less than or equal to the low limit, the event has `evt_rising`=0.
- R5: A frame whose value lies strictly between the two limits of its class produces no event.
- R6: After reset both high limits are 0xFF and both low limits are 0x00, and `evt_valid` is 0.
- R7: A write with `cfg_we`=1 selects a limit by `cfg_addr`: 0 cell high, 1 cell low, 2 aux high, 3 aux low. `cfg_wdata` is taken as a signed value. Negative values store 0, values above 255 store 255, and other values store as is. The new limit applies from the next cycle, so a frame in the same cycle as the write still sees the old limit.
- R8: A frame presented with `frame_crc_err`=1 produces no event.
- R9: An event is a single-cycle `evt_valid` pulse in the cycle after the frame is presented with `frame_valid`=1. It carries `evt_chan` equal to the frame's channel code. When `frame_valid`=0, no event follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Result frame present this cycle |
| frame_data | input | 32 | Result frame; channel in 26..23, value in 22..11 |
| frame_crc_err | input | 1 | Frame failed its integrity check; drop it |
| cfg_we | input | 1 | Limit write strobe |
| cfg_addr | input | 2 | Limit select (0 cell high, 1 cell low, 2 aux high, 3 aux low) |
| cfg_wdata | input | 16 | Signed limit value, saturated to 0..255 |
| evt_valid | output | 1 | Event pulse |
| evt_rising | output | 1 | 1 for a high crossing, 0 for a low crossing |
| evt_aux | output | 1 | 1 for an auxiliary channel, 0 for a cell channel |
| evt_chan | output | 4 | Channel code of the frame that raised the event |

## Verification
Every event is due exactly one clock edge after its frame is presented, and a limit write changes comparisons from the edge after it is written. The bench's reference model follows the same order. At each rising edge it first evaluates the frame against its stored limits, and only then applies any pending write. The outputs are compared half a cycle later on the falling edge, on every cycle. Directed cases cover the reset limits, the boundary values on both sides of each limit, the saturation of writes and the high-over-low priority. A long run of random frames and writes then exercises the same rules.

// File: rtl/thr_alert_pkg.sv
package thr_alert_pkg;
  localparam int FRAME_W   = 32;
  localparam int VAL_LSB   = 11;
  localparam int VAL_W     = 12;
  localparam int CH_LSB    = 23;
  localparam int CH_W      = 4;
  localparam int TH_W      = 8;
  localparam int N_LIMITS  = 4;
  localparam int LAST_CELL = 5;

  typedef enum logic [1:0] {
    LIM_CELL_HI = 2'd0,
    LIM_CELL_LO = 2'd1,
    LIM_AUX_HI  = 2'd2,
    LIM_AUX_LO  = 2'd3
  } lim_sel_e;

  typedef struct packed {
    logic            fire;
    logic            rising;
    logic            aux;
    logic [CH_W-1:0] chan;
  } evt_t;
endpackage

// File: rtl/thr_limit_regs.sv
module thr_limit_regs #(
  parameter int TH_W = 8,
  parameter int WD_W = 16,
  parameter int NLIM = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NLIM)-1:0] addr,
  input  logic [WD_W-1:0]         wdata,
  output logic [NLIM-1:0][TH_W-1:0] lim
);
  localparam logic [WD_W-1:0] TH_MAX = WD_W'((1 << TH_W) - 1);

  logic [TH_W-1:0] sat;

  always_comb begin
    if (wdata[WD_W-1])       sat = '0;
    else if (wdata > TH_MAX) sat = '1;
    else                     sat = wdata[TH_W-1:0];
  end

  for (genvar i = 0; i < NLIM; i++) begin : g_lim
    localparam logic [TH_W-1:0] RST_VAL = (i % 2 == 0) ? {TH_W{1'b1}} : {TH_W{1'b0}};
    always_ff @(posedge clk) begin
      if (rst)                     lim[i] <= RST_VAL;
      else if (we && addr == i)    lim[i] <= sat;
    end
  end

  AST_HI_RESET: assert property (@(posedge clk) $past(rst) |-> (lim[0] == '1 && lim[2] == '1 && lim[1] == '0 && lim[3] == '0)); // R6
  AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (rst) ($past(we) && $past(wdata[WD_W-1])) |-> lim[$past(addr)] == '0); // R7
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (!$past(we) && !$past(rst)) |-> $stable(lim)); // R7
endmodule

// File: rtl/thr_classify.sv
module thr_classify
  import thr_alert_pkg::*;
#(
  parameter int FW   = FRAME_W,
  parameter int TW   = TH_W
) (
  input  logic          valid,
  input  logic          crc_err,
  input  logic [FW-1:0] frame,
  input  logic [TW-1:0] cell_hi,
  input  logic [TW-1:0] cell_lo,
  input  logic [TW-1:0] aux_hi,
  input  logic [TW-1:0] aux_lo,
  output evt_t          evt
);
  logic [CH_W-1:0]  ch;
  logic [VAL_W-1:0] val;
  logic             is_aux;
  logic [VAL_W-1:0] hi_ext, lo_ext;
  logic             over, under;

  always_comb begin
    ch     = frame[CH_LSB +: CH_W];
    val    = frame[VAL_LSB +: VAL_W];
    is_aux = (ch > CH_W'(LAST_CELL));
    hi_ext = VAL_W'(is_aux ? aux_hi : cell_hi);
    lo_ext = VAL_W'(is_aux ? aux_lo : cell_lo);
    over   = (val >= hi_ext);
    under  = (val <= lo_ext);
    evt.fire   = valid && !crc_err && (over || under);
    evt.rising = over;
    evt.aux    = is_aux;
    evt.chan   = ch;
  end
endmodule

// File: rtl/thr_alert_top.sv
module thr_alert_top
  import thr_alert_pkg::*;
#(
  parameter int WD_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               frame_crc_err,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [WD_W-1:0]    cfg_wdata,
  output logic               evt_valid,
  output logic               evt_rising,
  output logic               evt_aux,
  output logic [CH_W-1:0]    evt_chan
);
  logic [N_LIMITS-1:0][TH_W-1:0] lim;
  evt_t nxt;

  thr_limit_regs #(.TH_W(TH_W), .WD_W(WD_W), .NLIM(N_LIMITS)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .lim(lim)
  );

  thr_classify #(.FW(FRAME_W), .TW(TH_W)) u_cls (
    .valid(frame_valid), .crc_err(frame_crc_err), .frame(frame_data),
    .cell_hi(lim[LIM_CELL_HI]), .cell_lo(lim[LIM_CELL_LO]),
    .aux_hi(lim[LIM_AUX_HI]), .aux_lo(lim[LIM_AUX_LO]),
    .evt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid  <= 1'b0;
      evt_rising <= 1'b0;
      evt_aux    <= 1'b0;
      evt_chan   <= '0;
    end else begin
      evt_valid  <= nxt.fire;
      evt_rising <= nxt.rising;
      evt_aux    <= nxt.aux;
      evt_chan   <= nxt.chan;
    end
  end

  AST_EVT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst) evt_valid |-> $past(frame_valid)); // R9
  AST_CRC_DROP: assert property (@(posedge clk) disable iff (rst) ($past(frame_valid) && $past(frame_crc_err)) |-> !evt_valid); // R8
  AST_CHAN_ECHO: assert property (@(posedge clk) disable iff (rst) evt_valid |-> evt_chan == $past(frame_data[CH_LSB +: CH_W])); // R9
  AST_AUX_CLASS: assert property (@(posedge clk) disable iff (rst) evt_valid |-> (evt_aux == (evt_chan > CH_W'(LAST_CELL)))); // R2
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !evt_valid); // R6
endmodule

// File: tb/thr_alert_top_tb_top.sv
`timescale 1ns/1ps
module thr_alert_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        frame_valid, frame_crc_err, cfg_we;
  logic [31:0] frame_data;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        evt_valid, evt_rising, evt_aux;
  logic [3:0]  evt_chan;

  int n_checks = 0;
  int n_errs   = 0;
  int mlim[4];
  bit finished = 0;

  always #2 clk = ~clk;

  thr_alert_top dut_i (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
    .frame_crc_err(frame_crc_err), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .evt_valid(evt_valid), .evt_rising(evt_rising),
    .evt_aux(evt_aux), .evt_chan(evt_chan)
  );

  function automatic logic [31:0] mk(input int ch, input int val);
    return (32'h1A << 27) | (32'(ch) << 23) | (32'(val) << 11) | 32'h155;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit crc, input logic [31:0] f,
                     input bit we, input int a, input int wd, input string tag);
    int ch, val, hi, lo, sat;
    bit ev, er, ea;
    frame_valid = v; frame_crc_err = crc; frame_data = f;
    cfg_we = we; cfg_addr = 2'(a); cfg_wdata = 16'(wd);
    @(posedge clk);
    ch  = int'(f[26:23]);
    val = int'(f[22:11]);
    ea  = ch > 5;
    hi  = ea ? mlim[2] : mlim[0];
    lo  = ea ? mlim[3] : mlim[1];
    er  = val >= hi;
    ev  = v && !crc && (er || val <= lo);
    if (we) begin
      sat = (wd >= 32768 || wd < 0) ? 0 : (wd > 255 ? 255 : wd);
      mlim[a] = sat;
    end
    @(negedge clk);
    chk(tag, int'(evt_valid), int'(ev), "evt_valid");
    if (ev) begin
      chk(tag, int'(evt_rising), int'(er), "evt_rising");
      chk(tag, int'(evt_aux), int'(ea), "evt_aux");
      chk(tag, int'(evt_chan), ch, "evt_chan");
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1; frame_valid = 0; frame_crc_err = 0; frame_data = '0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    mlim[0] = 255; mlim[1] = 0; mlim[2] = 255; mlim[3] = 0;
    repeat (3) @(negedge clk);
    chk("R6", int'(evt_valid), 0, "evt_valid in reset");
    rst = 0;
    // R6 reset limits, R4/R3/R5 boundaries
    cyc(1, 0, mk(0, 0),     0, 0, 0, "R6");
    cyc(1, 0, mk(3, 255),   0, 0, 0, "R3");
    cyc(1, 0, mk(5, 254),   0, 0, 0, "R5");
    cyc(1, 0, mk(6, 255),   0, 0, 0, "R2");
    cyc(1, 0, mk(15, 0),    0, 0, 0, "R2");
    cyc(1, 0, mk(12, 4095), 0, 0, 0, "R2");
    // R7 writes and timing of new limits
    cyc(1, 0, mk(1, 100),   1, 0, 100, "R7");
    cyc(1, 0, mk(1, 100),   1, 1, 50,  "R1");
    cyc(1, 0, mk(1, 99),    0, 0, 0,   "R5");
    cyc(1, 0, mk(1, 50),    0, 0, 0,   "R4");
    cyc(1, 0, mk(4, 51),    0, 0, 0,   "R5");
    cyc(1, 0, mk(7, 100),   0, 0, 0,   "R2");
    cyc(0, 0, mk(0, 0),     1, 2, 300, "R7");
    cyc(0, 0, mk(0, 0),     1, 3, -5,  "R7");
    cyc(1, 0, mk(8, 0),     1, 3, 4000, "R7");
    cyc(1, 0, mk(9, 200),   0, 0, 0,   "R4");
    cyc(1, 0, mk(9, 255),   0, 0, 0,   "R3");
    cyc(0, 0, mk(0, 0),     1, 1, 200, "R7");
    cyc(1, 0, mk(2, 150),   0, 0, 0,   "R3");
    // R8 dropped frames, R9 no frame
    cyc(1, 1, mk(2, 4095),  0, 0, 0,   "R8");
    cyc(1, 1, mk(10, 0),    0, 0, 0,   "R8");
    cyc(0, 0, mk(2, 4095),  0, 0, 0,   "R9");
    cyc(1, 0, mk(2, 4095),  0, 0, 0,   "R9");
    cyc(1, 0, mk(11, 255),  0, 0, 0,   "R9");
    for (int i = 0; i < 2000; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 8) == 0,
          mk($urandom % 16, $urandom % 4096 >> ($urandom % 4)),
          ($urandom % 6) == 0, $urandom % 4, int'($urandom % 700) - 200, "R9");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule